// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times a single external-memory read access for a bus controller that splits its address space into eight numbered areas. When it is idle and a request arrives with an area number, it takes the area's class and settings and plays out the bus states that make up the access, one state per clock cycle. It also decides whether the active-low WAIT pin may stretch the access, and when.

There are two kinds of area. In the plain areas (1, 3, 4, 5, 7) the per-area wait-enable bit picks between a one-state access and a two-state access that the pin can stretch. In the long-wait areas (0, 2, 6) a shared 2-bit long-wait count always adds fixed states, and the enable bit also lets the pin add more. Area 3 never responds to the pin, because on the board that pin is used for another chip-select function. The configuration is captured when the request is accepted. The caller watches the bus-state code, the final-state strobe and a one-cycle done pulse.

Top module: `ext_wait_ctl`

## Requirements
- R1: A synchronous active-high reset, even in the middle of an access, makes the next cycle show bus_state 0 with last_o and done_o both low.
- R2: In a plain area (1, 4, 5, 7, or 3) with its enable bit clear, the access is one state long, that state is final, and WAIT is never looked at.
- R3: In a plain area other than 3 with its enable bit set, the access is 2 + P states long, where P is the number of consecutive low WAIT samples taken from the sampling edge onward.
- R4: WAIT is sampled only on the clock edge that would otherwise move the access into its final state, and again at the end of each pin-wait state. A low level at any earlier edge has no effect.
- R5: In area 3 with its enable bit set, the access is exactly two states long whatever WAIT does.
- R6: In a long-wait area (0, 2, 6) with its enable bit clear, the access is 1 + L states long, where L is the long-wait count (0 to 3), and WAIT is ignored.
- R7: In a long-wait area with its enable bit set, the access is 1 + L + P states long. Pin waits follow the long waits, so with L = 0 the sampling edge is the edge that accepts the request.
- R8: bus_state encodes 0 = idle, 1 = leading state (the first state or a long-wait state, not final), 2 = pin-wait state, 3 = final state. last_o is high in exactly the cycles where bus_state is 3.
- R9: done_o is high for exactly one cycle, the cycle right after the final state, and bus_state is 0 in that cycle.
- R10: A request is taken only when bus_state is 0. While an access runs, a held request and changes to wait_en or long_cnt do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_area | input | 3 | Area number of the request |
| wait_en | input | 8 | Wait-enable bit per area, bit n for area n |
| long_cnt | input | 2 | Long-wait state count for areas 0, 2, 6 |
| wait_n | input | 1 | External WAIT pin, active low |
| bus_state | output | 2 | Current bus state code (R8) |
| last_o | output | 1 | High during the final state |
| done_o | output | 1 | One-cycle pulse after the final state |

## Verification
The sweep runs every area with both enable settings, all four long-wait counts, and 0, 1 or 2 pin-wait samples. That sets the short class apart from the long class, and the pin-honouring configurations apart from those that must ignore the pin, including area 3. WAIT is held low for every edge before the sampling point. Any sampling that comes too early shows up as an access that is too long in the configurations where the pin is enabled. In the configurations where it is not, WAIT is held low for the whole access, which shows whether the pin is properly ignored. Separate runs hold a request and change the configuration during an access, and assert reset in the middle of a long access.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_LEAD = 2'd1,
    BS_PINW = 2'd2,
    BS_LAST = 2'd3
  } bus_state_e;

endpackage

// File: rtl/ewc_area_class.sv
module ewc_area_class #(
  parameter int NUM_AREAS = 8,
  parameter int LW_W = 2,
  parameter logic [NUM_AREAS-1:0] LONG_MASK = 8'b0100_0101,
  parameter logic [NUM_AREAS-1:0] NOPIN_MASK = 8'b0000_1000,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic [AREA_W-1:0]    area,
  input  logic [NUM_AREAS-1:0] wait_en,
  input  logic [LW_W-1:0]      long_cnt,
  output logic [LW_W-1:0]      lead_cnt,
  output logic                 pin_ok
);

  logic [LW_W-1:0]      lead_a [NUM_AREAS];
  logic [NUM_AREAS-1:0] pin_a;

  for (genvar gi = 0; gi < NUM_AREAS; gi++) begin : g_area
    if (LONG_MASK[gi]) begin : g_long
      assign lead_a[gi] = long_cnt;
    end else begin : g_short
      assign lead_a[gi] = LW_W'(wait_en[gi]);
    end
    assign pin_a[gi] = wait_en[gi] & ~NOPIN_MASK[gi];
  end

  assign lead_cnt = lead_a[area];
  assign pin_ok   = pin_a[area];

endmodule

// File: rtl/ewc_seq.sv
module ewc_seq
  import ewc_pkg::*;
#(
  parameter int LW_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [LW_W-1:0] lead_cnt,
  input  logic            pin_ok,
  input  logic            wait_n,
  output bus_state_e      state,
  output logic            last,
  output logic            done
);

  bus_state_e      st_q, st_d;
  logic [LW_W-1:0] cnt_q, cnt_d;
  logic            pin_q, pin_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pin_d = pin_q;
    unique case (st_q)
      BS_IDLE: begin
        if (start) begin
          pin_d = pin_ok;
          if (lead_cnt != '0) begin
            st_d  = BS_LEAD;
            cnt_d = lead_cnt - 1'b1;
          end else if (pin_ok && !wait_n) begin
            st_d = BS_PINW;
          end else begin
            st_d = BS_LAST;
          end
        end
      end
      BS_LEAD: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (pin_q && !wait_n) begin
          st_d = BS_PINW;
        end else begin
          st_d = BS_LAST;
        end
      end
      BS_PINW: begin
        if (wait_n) st_d = BS_LAST;
      end
      BS_LAST: begin
        st_d = BS_IDLE;
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
      pin_q <= 1'b0;
      last  <= 1'b0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pin_q <= pin_d;
      last  <= (st_d == BS_LAST);
      done  <= (st_q == BS_LAST);
    end
  end

  assign state = st_q;

endmodule

// File: rtl/ext_wait_ctl.sv
module ext_wait_ctl
  import ewc_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int LW_W = 2,
  parameter logic [NUM_AREAS-1:0] LONG_MASK = 8'b0100_0101,
  parameter logic [NUM_AREAS-1:0] NOPIN_MASK = 8'b0000_1000,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [AREA_W-1:0]    req_area,
  input  logic [NUM_AREAS-1:0] wait_en,
  input  logic [LW_W-1:0]      long_cnt,
  input  logic                 wait_n,
  output logic [1:0]           bus_state,
  output logic                 last_o,
  output logic                 done_o
);

  logic [LW_W-1:0] lead_cnt;
  logic            pin_ok;
  logic            start;
  bus_state_e      st;

  ewc_area_class #(
    .NUM_AREAS (NUM_AREAS),
    .LW_W      (LW_W),
    .LONG_MASK (LONG_MASK),
    .NOPIN_MASK(NOPIN_MASK)
  ) u_class (
    .area    (req_area),
    .wait_en (wait_en),
    .long_cnt(long_cnt),
    .lead_cnt(lead_cnt),
    .pin_ok  (pin_ok)
  );

  assign start = req_valid && (st == BS_IDLE);

  ewc_seq #(
    .LW_W(LW_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .lead_cnt(lead_cnt),
    .pin_ok  (pin_ok),
    .wait_n  (wait_n),
    .state   (st),
    .last    (last_o),
    .done    (done_o)
  );

  assign bus_state = st;

endmodule

// File: rtl/ext_wait_ctl_chk.sv
module ext_wait_ctl_chk #(
  parameter int NUM_AREAS = 8,
  parameter logic [NUM_AREAS-1:0] NOPIN_MASK = 8'b0000_1000,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [AREA_W-1:0]    req_area,
  input logic [NUM_AREAS-1:0] wait_en,
  input logic                 wait_n,
  input logic [1:0]           bus_state,
  input logic                 last_o,
  input logic                 done_o
);

  logic pin_allowed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_allowed_q <= 1'b0;
    end else if (bus_state == 2'd0 && req_valid) begin
      pin_allowed_q <= wait_en[req_area] & ~NOPIN_MASK[req_area];
    end
  end

  p_pinw_allowed_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_state == 2'd2) |-> pin_allowed_q);

  p_pin_low_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_state == 2'd2 && !wait_n) |=> (bus_state == 2'd2));

  p_pin_high_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_state == 2'd2 && wait_n) |=> (bus_state == 2'd3));

  p_last_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (bus_state == 2'd0));

  p_idle_not_last_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_state == 2'd0) |-> !last_o);

  p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
    last_o |=> done_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (bus_state == 2'd0));

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_state == 2'd0 && !req_valid) |=> (bus_state == 2'd0));

endmodule

bind ext_wait_ctl ext_wait_ctl_chk #(
  .NUM_AREAS (NUM_AREAS),
  .NOPIN_MASK(NOPIN_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_area (req_area),
  .wait_en  (wait_en),
  .wait_n   (wait_n),
  .bus_state(bus_state),
  .last_o   (last_o),
  .done_o   (done_o)
);

// File: tb/test_ext_wait_ctl.sv
`timescale 1ns/1ps
module test_ext_wait_ctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_area = '0;
  logic [7:0] wait_en = '0;
  logic [1:0] long_cnt = '0;
  logic       wait_n = 1'b1;
  logic [1:0] bus_state;
  logic       last_o;
  logic       done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ext_wait_ctl i_ext_wait_ctl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_area (req_area),
    .wait_en  (wait_en),
    .long_cnt (long_cnt),
    .wait_n   (wait_n),
    .bus_state(bus_state),
    .last_o   (last_o),
    .done_o   (done_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One access. busy=1 holds a request and flips the configuration mid-access (R10).
  task automatic run_access(int a, int en, int lw, int p, bit busy);
    bit is_long = (a == 0 || a == 2 || a == 6);
    int lead    = is_long ? lw : en;
    bit pin_ok  = (en != 0) && (a != 3);
    int n       = 1 + lead + (pin_ok ? p : 0);
    string tag;
    if (is_long) tag = en ? "R7" : "R6";
    else if (a == 3 && en != 0) tag = "R5";
    else tag = en ? "R3" : "R2";
    if (busy) tag = "R10";
    @(negedge clk);
    req_valid = 1'b1;
    req_area  = 3'(a);
    wait_en   = 8'(en) << a;
    long_cnt  = 2'(lw);
    // R4: WAIT is low at every edge before the sampling edge as well, and when pins are off
    wait_n    = pin_ok ? (lead + p > 0 ? 1'b0 : 1'b1) : 1'b0;
    for (int c = 1; c <= n + 1; c++) begin
      @(negedge clk);
      if (!busy && c == 1) req_valid = 1'b0;
      if (busy && c == 1) begin
        req_area = 3'(a ^ 1);
        wait_en  = ~wait_en;
        long_cnt = ~long_cnt;
      end
      if (busy && c == n) req_valid = 1'b0;
      if (c == n + 1) begin
        chk({tag, "/R9 idle after final"}, bus_state, 0);
        chk("R9 done pulse", done_o, 1);
        chk("R8 last low in idle", last_o, 0);
      end else if (c == n) begin
        chk({tag, "/R8 final state"}, bus_state, 3);
        chk("R8 last strobe", last_o, 1);
        chk("R9 no early done", done_o, 0);
      end else if (c <= lead) begin
        chk({tag, "/R8 leading state"}, bus_state, 1);
        chk("R8 last low when leading", last_o, 0);
      end else begin
        chk({tag, "/R4 pin-wait state"}, bus_state, 2);
        chk("R8 last low in pin wait", last_o, 0);
      end
      wait_n = pin_ok ? ((c < lead + p) ? 1'b0 : 1'b1) : 1'b0;
    end
    @(negedge clk);
    chk("R9 done single cycle", done_o, 0);
    chk({tag, " stays idle"}, bus_state, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", bus_state, 0);
    chk("R1 reset last", last_o, 0);
    chk("R1 reset done", done_o, 0);
    rst = 1'b0;

    for (int a = 0; a < 8; a++)
      for (int en = 0; en < 2; en++)
        for (int lw = 0; lw < 4; lw++)
          for (int p = 0; p < 3; p++)
            run_access(a, en, lw, p, 1'b0);

    run_access(1, 1, 0, 2, 1'b1);
    run_access(2, 0, 3, 0, 1'b1);
    run_access(6, 1, 1, 1, 1'b1);

    // R1: reset in the middle of a long access
    @(negedge clk);
    req_valid = 1'b1; req_area = 3'd0; wait_en = 8'h00; long_cnt = 2'd3; wait_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 access running", bus_state, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-access reset state", bus_state, 0);
    chk("R1 mid-access reset last", last_o, 0);
    chk("R1 mid-access reset done", done_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", bus_state, 0);
    chk("R1 no done after reset", done_o, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule